// File: doc/BRIEF.md
# Masked Interrupt Status Controller

This block holds the interrupt bookkeeping of a host controller. It keeps a status word that internal logic sets through one-cycle event pulses, and an enable mask whose top bit is a master gate. From these it drives a single level-sensitive interrupt line. Software reaches the block through a 32-bit register port with a 2-bit select.

Software acknowledges a cause by writing a 1 to the matching status bit. The enable mask has two write views. One view only adds bits to the mask and the other only removes them, so no read-modify-write sequence is needed and no race can occur. The interrupt line is registered, so it follows any change of status or mask by one clock.

Implemented status positions are 0 (scheduling overrun), 1 (done-list writeback), 2 (frame start), 3 (resume detect), 4 (unrecoverable error), 5 (frame counter overflow), 6 (root hub change) and 30 (ownership change). Every other status position is fixed at 0.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset the status reads 0, the enable mask reads 0x8000_0000 (master enable only) and irq_o is low.
- R2: An event pulse on a bit of event_i sets the status bit at that position only for positions 0..6 and 30. Events on any other position are ignored, and those status bits always read 0.
- R3: A write with sel_i=0 clears every status bit written as 1 and leaves the bits written as 0 unchanged.
- R4: When an event and a status write that clears the same bit fall in the same cycle, the event wins and the bit reads 1 afterwards.
- R5: A write with sel_i=1 ORs wdata_i into the enable mask. A read with sel_i=1 returns the mask.
- R6: A write with sel_i=2 clears the mask bits written as 1. A read with sel_i=2 returns the bitwise complement of the mask.
- R7: sel_i=3 reads 0, and writes with sel_i=3 change neither status nor mask.
- R8: irq_o is high in a cycle exactly when, at the previous clock edge, mask bit 31 was set and status AND mask[30:0] was nonzero. The output thus lags a status or mask change by one clock.
- R9: While mask bit 31 is clear, irq_o is low at the following edge, whatever the pending causes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| we_i | input | 1 | Register write strobe |
| sel_i | input | 2 | Register select: 0 status, 1 enable-set, 2 enable-clear, 3 unused |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for the selected register (combinational) |
| event_i | input | 32 | One-cycle event pulses that set status bits |
| irq_o | output | 1 | Registered interrupt level |

## Verification
The bench targets a set and a clear that land on the same bit in one cycle. A design where the clear won would drop a cause and lose an interrupt. Every one of the 32 positions receives an event, so a design that flopped unimplemented positions would show stray status bits. The enable-clear view is read back after each step to catch a read that returns the mask itself instead of its complement. The bench also samples irq_o in the cycle right after a change, which exposes both a combinational output (high one cycle early) and a missing master gate (high with bit 31 clear).

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned IRQ_DATA_W = 32;
  localparam logic [IRQ_DATA_W-1:0] IRQ_IMPL_MASK = 32'h4000_007F;

  typedef enum logic [1:0] {
    SEL_STATUS = 2'd0,
    SEL_EN_SET = 2'd1,
    SEL_EN_CLR = 2'd2,
    SEL_NONE   = 2'd3
  } irq_sel_e;
endpackage

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
  parameter int unsigned DATA_W = 32,
  parameter logic [DATA_W-1:0] IMPL_MASK = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_en_i,
  input  logic [DATA_W-1:0] clr_bits_i,
  input  logic [DATA_W-1:0] event_i,
  output logic [DATA_W-1:0] status_o
);
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    if (IMPL_MASK[i]) begin : g_flop
      logic bit_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) bit_q <= 1'b0;
        // event has priority over a same-cycle clear
        else if (event_i[i]) bit_q <= 1'b1;
        else if (clr_en_i && clr_bits_i[i]) bit_q <= 1'b0;
      end
      assign status_o[i] = bit_q;
    end else begin : g_tie
      assign status_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_en_i,
  input  logic              clr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] mask_o
);
  localparam logic [DATA_W-1:0] RstVal = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DATA_W-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_q <= RstVal;
    else if (set_en_i) mask_q <= mask_q | wdata_i;
    else if (clr_en_i) mask_q <= mask_q & ~wdata_i;
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/irq_level_gen.sv
module irq_level_gen #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] status_i,
  input  logic [DATA_W-1:0] mask_i,
  output logic              irq_o
);
  localparam int unsigned MasterBit = DATA_W - 1;

  logic pending;
  logic irq_q;

  assign pending = |(status_i[MasterBit-1:0] & mask_i[MasterBit-1:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else irq_q <= mask_i[MasterBit] & pending;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import irq_pkg::*;
#(
  parameter int unsigned DATA_W = IRQ_DATA_W,
  parameter logic [DATA_W-1:0] IMPL_MASK = IRQ_IMPL_MASK
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [1:0]        sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [DATA_W-1:0] event_i,
  output logic              irq_o
);
  irq_sel_e sel;
  logic wr_status, wr_set, wr_clr;
  logic [DATA_W-1:0] status_w, mask_w;

  assign sel       = irq_sel_e'(sel_i);
  assign wr_status = we_i && (sel == SEL_STATUS);
  assign wr_set    = we_i && (sel == SEL_EN_SET);
  assign wr_clr    = we_i && (sel == SEL_EN_CLR);

  irq_status_bank #(.DATA_W(DATA_W), .IMPL_MASK(IMPL_MASK)) u_status (
    .clk_i, .rst_ni,
    .clr_en_i  (wr_status),
    .clr_bits_i(wdata_i),
    .event_i,
    .status_o  (status_w)
  );

  irq_mask_reg #(.DATA_W(DATA_W)) u_mask (
    .clk_i, .rst_ni,
    .set_en_i(wr_set),
    .clr_en_i(wr_clr),
    .wdata_i,
    .mask_o  (mask_w)
  );

  irq_level_gen #(.DATA_W(DATA_W)) u_level (
    .clk_i, .rst_ni,
    .status_i(status_w),
    .mask_i  (mask_w),
    .irq_o
  );

  always_comb begin
    unique case (sel)
      SEL_STATUS: rdata_o = status_w;
      SEL_EN_SET: rdata_o = mask_w;
      SEL_EN_CLR: rdata_o = ~mask_w;
      default:    rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/irq_status_ctrl_sva.sv
module irq_status_ctrl_sva #(
  parameter int unsigned DATA_W = 32,
  parameter logic [DATA_W-1:0] IMPL_MASK = '1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_i,
  input logic [1:0]        sel_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] event_i,
  input logic [DATA_W-1:0] status_q,
  input logic [DATA_W-1:0] mask_q,
  input logic              irq_o
);
  localparam int unsigned Mb = DATA_W - 1;

  assert_unimpl_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_q & ~IMPL_MASK) == '0);

  assert_w1c_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel_i == 2'd0 && event_i == '0) |=> ((status_q & $past(wdata_i)) == '0));

  assert_event_wins_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((event_i & IMPL_MASK) != '0) |=>
      ((status_q & $past(event_i & IMPL_MASK)) == $past(event_i & IMPL_MASK)));

  assert_set_or_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel_i == 2'd1) |=> ((mask_q & $past(wdata_i)) == $past(wdata_i)));

  assert_clr_mask_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel_i == 2'd2) |=> ((mask_q & $past(wdata_i)) == '0));

  assert_unused_sel_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel_i == 2'd3 && event_i == '0) |=> ($stable(status_q) && $stable(mask_q)));

  assert_level_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(mask_q[Mb] && ((status_q[Mb-1:0] & mask_q[Mb-1:0]) != '0)));

  assert_master_gate_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mask_q[Mb] |=> !irq_o);
endmodule

bind irq_status_ctrl irq_status_ctrl_sva #(.DATA_W(DATA_W), .IMPL_MASK(IMPL_MASK)) sva_i (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .we_i    (we_i),
  .sel_i   (sel_i),
  .wdata_i (wdata_i),
  .event_i (event_i),
  .status_q(status_w),
  .mask_q  (mask_w),
  .irq_o   (irq_o)
);

// File: tb/irq_status_ctrl_tb_top.sv
module irq_status_ctrl_tb_top;
  localparam int unsigned CLK_PERIOD = 10;
  localparam logic [31:0] IMPL = 32'h4000_007F;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we_i = 1'b0;
  logic [1:0]  sel_i = 2'd3;
  logic [31:0] wdata_i = '0;
  logic [31:0] event_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o;

  int checks = 0;
  int errors = 0;

  logic [31:0] m_status = '0;
  logic [31:0] m_mask = 32'h8000_0000;
  logic        exp_irq = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_status_ctrl dut_i (
    .clk_i(clk), .rst_ni, .we_i, .sel_i, .wdata_i, .rdata_o, .event_i, .irq_o
  );

  function automatic logic irq_fn(logic [31:0] s, logic [31:0] m);
    return m[31] && ((s[30:0] & m[30:0]) != '0);
  endfunction

  task automatic cmp(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // read all views in the low clock phase, no edge in between
  task automatic check_all(string tag);
    sel_i = 2'd0; #1; cmp(tag, "status", rdata_o, m_status);
    sel_i = 2'd1; #1; cmp(tag, "en_set", rdata_o, m_mask);
    sel_i = 2'd2; #1; cmp(tag, "en_clr", rdata_o, ~m_mask);
    cmp(tag, "irq", {31'd0, irq_o}, {31'd0, exp_irq});
  endtask

  task automatic step(string tag, logic we, logic [1:0] sel, logic [31:0] wd, logic [31:0] ev);
    @(negedge clk);
    we_i = we; sel_i = sel; wdata_i = wd; event_i = ev;
    @(posedge clk);
    exp_irq = irq_fn(m_status, m_mask);
    if (we && sel == 2'd0) m_status = m_status & ~wd;
    m_status = m_status | (ev & IMPL);
    if (we && sel == 2'd1) m_mask = m_mask | wd;
    if (we && sel == 2'd2) m_mask = m_mask & ~wd;
    @(negedge clk);
    we_i = 1'b0; event_i = '0; wdata_i = '0;
    check_all(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] lfsr = 32'hACE1_1234;
    #(CLK_PERIOD * 3);
    // R1 reset values
    check_all("R1");
    sel_i = 2'd3; #1; cmp("R1", "unused_rd", rdata_o, '0);
    @(negedge clk); rst_ni = 1'b1;
    check_all("R1");

    // R2 every position, then clear
    for (int b = 0; b < 32; b++) begin
      step("R2", 1'b0, 2'd3, '0, 32'd1 << b);
      step("R3", 1'b1, 2'd0, 32'd1 << b, '0);
    end
    // R3 partial clear leaves zeros-written bits
    step("R2", 1'b0, 2'd0, '0, 32'hFFFF_FFFF);
    step("R3", 1'b1, 2'd0, 32'h0000_0015, '0);
    step("R3", 1'b1, 2'd0, 32'hFFFF_FFFF, '0);
    // R4 event versus clear on the same bit
    step("R2", 1'b0, 2'd3, '0, 32'h0000_0004);
    step("R4", 1'b1, 2'd0, 32'h0000_0004, 32'h0000_0004);
    step("R4", 1'b1, 2'd0, 32'h4000_0004, 32'h4000_0000);
    step("R3", 1'b1, 2'd0, 32'hFFFF_FFFF, '0);

    // R5 / R6 each mask bit
    for (int b = 0; b < 31; b++) begin
      step("R5", 1'b1, 2'd1, 32'd1 << b, '0);
      step("R6", 1'b1, 2'd2, 32'd1 << b, '0);
    end
    // R7 unused select ignored
    step("R7", 1'b1, 2'd3, 32'hFFFF_FFFF, '0);
    sel_i = 2'd3; #1; cmp("R7", "unused_rd", rdata_o, '0);

    // R8 latency: enable bit 0, fire event, watch irq lag
    step("R5", 1'b1, 2'd1, 32'h0000_0001, '0);
    step("R8", 1'b0, 2'd3, '0, 32'h0000_0001);   // irq still low here
    step("R8", 1'b0, 2'd3, '0, '0);              // now high
    step("R8", 1'b1, 2'd0, 32'h0000_0001, '0);   // cleared, irq one more cycle
    step("R8", 1'b0, 2'd3, '0, '0);
    // R8 status pending but not enabled
    step("R8", 1'b0, 2'd3, '0, 32'h0000_0040);
    step("R8", 1'b0, 2'd3, '0, '0);
    step("R8", 1'b1, 2'd1, 32'h0000_0040, '0);
    step("R8", 1'b0, 2'd3, '0, '0);
    // R9 master gate
    step("R9", 1'b1, 2'd2, 32'h8000_0000, '0);
    step("R9", 1'b0, 2'd3, '0, '0);
    step("R9", 1'b0, 2'd3, '0, 32'h4000_0000);
    step("R9", 1'b1, 2'd1, 32'hC000_0000, '0);
    step("R9", 1'b0, 2'd3, '0, '0);

    // mixed pseudo-random traffic
    for (int n = 0; n < 400; n++) begin
      logic [31:0] a;
      logic [31:0] ev;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      a = lfsr;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      ev = (lfsr[3:0] == 4'd0) ? (a ^ lfsr) : '0;
      step("R8", lfsr[7], lfsr[9:8], a & {lfsr[31:16], lfsr[15:0] | 16'h0}, ev);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule